// File: doc/BRIEF.md
# I2S Master Transmitter with Word FIFO

This block turns a stream of audio sample words into a master-mode I2S serial stream. Words enter an 8-deep FIFO through a valid/ready port. A serializer takes them one slot at a time and shifts each sample out MSB first. The block drives the serial clock, word select and serial data pins. A programmable divider sets the bit period to an integer number of system clock cycles. To pick the divider value, multiply the sample rate, the slot width and the number of slots per frame: 48 kHz stereo at 16 bits needs 1.536 Mbit/s.

The slot width can be 8, 16 or 32 bits. In stereo mode the slots alternate left and right, one FIFO word per slot. In mono mode one word fills both slots of a frame. When the FIFO runs dry, the last word sent is transmitted again, so no glitch to silence occurs. A mute input forces the data line to zero and leaves the timing untouched. The FIFO fill level is brought out so that an external comparator can raise a refill interrupt. Width, mono and divider changes are held back until the next frame begins.

Top module: `i2s_tx_master`

## Requirements
- R1: With divider value N, one bit lasts N+1 clock cycles. Within a bit, sck is low for floor((N+1)/2) cycles and then high for the remaining cycles. With N=0, sck stays high.
- R2: sd and ws change only in the first cycle of a bit. For N≥1, sck is low in that cycle. sd never changes between two cycles in which sck is high.
- R3: Width code 0 selects 8-bit slots, 1 selects 16-bit slots, and 2 or 3 select 32-bit slots. Each slot carries the low W bits of its word, MSB first. ws is 0 for the left slot and 1 for the right slot. ws switches on the last bit of the preceding slot, one bit before the MSB.
- R4: In stereo mode (cfg_mono=0), consecutive FIFO words fill consecutive slots in the order left, right, left, right.
- R5: In mono mode (cfg_mono=1), one word is taken at the start of each frame and sent in both the left and the right slot.
- R6: When a slot starts with the FIFO empty, the most recently sent word is sent again. After reset this held word is 0.
- R7: While cfg_mute is 1 at a bit boundary, the next bit on sd is 0. ws and sck keep running, and the FIFO is still drained at the normal pace.
- R8: The FIFO holds 8 words. in_ready is 1 exactly when fifo_level < 8. A word is accepted on a clock edge where in_valid and in_ready are both 1. A word offered while in_ready is 0 is dropped. fifo_level counts the stored words.
- R9: cfg_width, cfg_mono and cfg_rate are sampled only at the start of a frame, so both slots of every frame have the same width.
- R10: During and after reset, sck, ws and sd are 0, fifo_level is 0 and in_ready is 1. The first frame uses the configuration present at the first clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the source of the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rate | input | 10 | Divider value N; one bit lasts N+1 clock cycles |
| cfg_width | input | 2 | Slot width code: 0 for 8 bits, 1 for 16 bits, 2 or 3 for 32 bits |
| cfg_mono | input | 1 | 1: one word per frame, repeated in both slots |
| cfg_mute | input | 1 | 1: force the data output to 0 |
| in_data | input | 32 | Sample word, right-aligned |
| in_valid | input | 1 | in_data holds a word to store |
| in_ready | output | 1 | FIFO has room for a word |
| fifo_level | output | 4 | Number of words in the FIFO |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select: 0 for left, 1 for right |
| sd | output | 1 | Serial data, MSB first |

## Verification
The bench sweeps the divider over several values, including 0, and measures the bit period and the high time of sck. A divider that is off by one, or a mis-computed high phase, shows up directly in those counts. A behavioural receiver rebuilds the words from ws transitions, so the checks catch a ws that switches on the MSB instead of one bit earlier, a slot that uses the wrong bits of the word, and a mono or stereo mode that pops the wrong number of words. Underflow is checked by letting the FIFO drain: a design that sent zeros or stale FIFO contents would break the run of repeated last words. Further cases change the width in the middle of a frame, offer a word while the FIFO is full, and mute while words are still queued. A design that applied a new width immediately would send a frame with unequal slots. One that accepted a word while full would send it later. One that held the FIFO while muted would send queued words after unmute instead of repeating the last one.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;

   typedef enum logic [1:0] {
      SW_8   = 2'd0,
      SW_16  = 2'd1,
      SW_32  = 2'd2,
      SW_32X = 2'd3
   } slot_w_e;

   localparam int unsigned IDX_W = 7;

   function automatic logic [IDX_W-1:0] slot_len(input slot_w_e w);
      case (w)
         SW_8:    slot_len = 7'd8;
         SW_16:   slot_len = 7'd16;
         default: slot_len = 7'd32;
      endcase
   endfunction

endpackage

// File: rtl/i2stx_fifo.sv
module i2stx_fifo #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [DW-1:0]                    wr_data,
   input  logic                             wr_valid,
   output logic                             wr_ready,
   output logic [DW-1:0]                    rd_data,
   input  logic                             rd_pop,
   output logic                             rd_empty,
   output logic [$clog2(DEPTH+1)-1:0]       level
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned LW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("i2stx_fifo: DEPTH must be a power of two of at least 2");
      end
      if (DW < 1) begin : g_bad_width
         $error("i2stx_fifo: DW must be positive");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [LW-1:0] count_q;
   logic          push, pop;

   assign wr_ready = (count_q != LW'(DEPTH));
   assign rd_empty = (count_q == '0);
   assign push     = wr_valid & wr_ready;
   assign pop      = rd_pop & ~rd_empty;
   assign rd_data  = mem[rp_q];
   assign level    = count_q;

   always_ff @(posedge clk) begin
      if (push) mem[wp_q] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q    <= '0;
         rp_q    <= '0;
         count_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
         case ({push, pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= LW'(DEPTH));

   a_r8_level_up: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/i2stx_bitclk.sv
module i2stx_bitclk #(
   parameter int unsigned RATE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] cfg_rate,
   input  logic              load_cfg,
   output logic              bit_end,
   output logic              sck
);
   localparam int unsigned CW = RATE_W + 1;

   generate
      if (RATE_W < 1 || RATE_W > 16) begin : g_bad_rate
         $error("i2stx_bitclk: RATE_W out of range");
      end
   endgenerate

   logic [RATE_W-1:0] rate_q, cnt_q, rate_n, cnt_n;
   logic [CW-1:0]     half_n;
   logic              sck_q, sck_n;

   assign bit_end = (cnt_q == rate_q);

   always_comb begin
      rate_n = load_cfg ? cfg_rate : rate_q;
      cnt_n  = bit_end ? '0 : cnt_q + 1'b1;
      half_n = ({1'b0, rate_n} + CW'(1)) >> 1;
      sck_n  = ({1'b0, cnt_n} >= half_n);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q <= '0;
         cnt_q  <= '0;
         sck_q  <= 1'b0;
      end else begin
         rate_q <= rate_n;
         cnt_q  <= cnt_n;
         sck_q  <= sck_n;
      end
   end

   assign sck = sck_q;

   a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= rate_q);

   a_r1_low_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bit_end) && rate_q != '0) |-> !sck_q);

endmodule

// File: rtl/i2stx_serializer.sv
module i2stx_serializer
   import i2stx_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_end,
   input  slot_w_e       cfg_width,
   input  logic          cfg_mono,
   input  logic          cfg_mute,
   input  logic [DW-1:0] fifo_data,
   input  logic          fifo_empty,
   output logic          fifo_pop,
   output logic          frame_load,
   output logic          ws,
   output logic          sd
);
   generate
      if (DW < 32) begin : g_bad_dw
         $error("i2stx_serializer: DW must hold a 32-bit slot");
      end
   endgenerate

   logic [IDX_W-1:0] bidx_q, bidx_n, sb_q, sb_n, nb, pos, selw;
   slot_w_e          wid_q, wid_n;
   logic             mono_q, mono_n;
   logic [DW-1:0]    word_q, word_n;
   logic             ws_q, sd_q, ws_n;
   logic             last, slot_start, right_n, take;
   logic [4:0]       sel;

   always_comb begin
      sb_q       = slot_len(wid_q);
      last       = (bidx_q == ({sb_q[IDX_W-2:0], 1'b0} - 7'd1));
      frame_load = bit_end & last;
      wid_n      = frame_load ? cfg_width : wid_q;
      mono_n     = frame_load ? cfg_mono  : mono_q;
      sb_n       = slot_len(wid_n);
      bidx_n     = last ? '0 : bidx_q + 7'd1;
      slot_start = last || (bidx_q == sb_q - 7'd1);
      right_n    = (bidx_n >= sb_n);
      take       = bit_end && slot_start && (!mono_n || !right_n) && !fifo_empty;
      word_n     = take ? fifo_data : word_q;
      pos        = bidx_n & (sb_n - 7'd1);
      selw       = sb_n - 7'd1 - pos;
      sel        = selw[4:0];
      nb         = bidx_n + 7'd1;
      ws_n       = (nb >= sb_n) && (nb < {sb_n[IDX_W-2:0], 1'b0});
   end

   assign fifo_pop = take;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bidx_q <= 7'd15;
         wid_q  <= SW_8;
         mono_q <= 1'b0;
         word_q <= '0;
         ws_q   <= 1'b0;
         sd_q   <= 1'b0;
      end else if (bit_end) begin
         bidx_q <= bidx_n;
         wid_q  <= wid_n;
         mono_q <= mono_n;
         word_q <= word_n;
         ws_q   <= ws_n;
         sd_q   <= cfg_mute ? 1'b0 : word_n[sel];
      end
   end

   assign ws = ws_q;
   assign sd = sd_q;

   a_r7_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bit_end && cfg_mute) |-> !sd_q);

   a_r9_width_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wid_q) |-> $past(frame_load));

   a_r3_ws_at_bit: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ws_q) |-> $past(bit_end));

endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master
   import i2stx_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FIFO_DEPTH = 8,
   parameter int unsigned RATE_W     = 10
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [RATE_W-1:0]                 cfg_rate,
   input  logic [1:0]                        cfg_width,
   input  logic                              cfg_mono,
   input  logic                              cfg_mute,
   input  logic [DATA_W-1:0]                 in_data,
   input  logic                              in_valid,
   output logic                              in_ready,
   output logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_level,
   output logic                              sck,
   output logic                              ws,
   output logic                              sd
);
   logic [DATA_W-1:0] head;
   logic              empty, pop, bit_end, frame_load;

   i2stx_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_data  (in_data),
      .wr_valid (in_valid),
      .wr_ready (in_ready),
      .rd_data  (head),
      .rd_pop   (pop),
      .rd_empty (empty),
      .level    (fifo_level)
   );

   i2stx_bitclk #(.RATE_W(RATE_W)) u_bitclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_rate (cfg_rate),
      .load_cfg (frame_load),
      .bit_end  (bit_end),
      .sck      (sck)
   );

   i2stx_serializer #(.DW(DATA_W)) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_end    (bit_end),
      .cfg_width  (slot_w_e'(cfg_width)),
      .cfg_mono   (cfg_mono),
      .cfg_mute   (cfg_mute),
      .fifo_data  (head),
      .fifo_empty (empty),
      .fifo_pop   (pop),
      .frame_load (frame_load),
      .ws         (ws),
      .sd         (sd)
   );

   a_r2_sd_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck) && !$past(bit_end)) |-> $stable(sd));

endmodule

// File: tb/tb_i2s_tx_master.sv
`timescale 1ns/1ps
module tb_i2s_tx_master;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  cfg_rate = '0;
   logic [1:0]  cfg_width = '0;
   logic        cfg_mono = 1'b0;
   logic        cfg_mute = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [3:0]  fifo_level;
   logic        sck, ws, sd;

   always #2 clk = ~clk;

   i2s_tx_master dut (
      .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_width(cfg_width),
      .cfg_mono(cfg_mono), .cfg_mute(cfg_mute), .in_data(in_data),
      .in_valid(in_valid), .in_ready(in_ready), .fifo_level(fifo_level),
      .sck(sck), .ws(ws), .sd(sd)
   );

   int n_chk = 0, n_err = 0, cyc = 0;
   bit cap_en = 0, cap_every = 0;
   logic sck_prev = 0, sd_prev = 0, pws = 0;
   int cur_len = 0, n_emit = 0, ones = 0, hold_viol = 0;
   logic [31:0] sh = '0;
   logic [31:0] em_w [256];
   int          em_len [256];
   logic        em_ch [256];
   logic [31:0] exp_w [16];

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   // behavioural receiver: capture at sck rise (or every cycle for N=0)
   always @(negedge clk) begin
      if (cap_en) begin
         if (!cap_every && sck && sck_prev && sd !== sd_prev) hold_viol++;
         if (cap_every || (sck && !sck_prev)) begin
            if (sd) ones++;
            sh = {sh[30:0], sd};
            cur_len++;
            if (ws !== pws) begin
               if (n_emit < 256) begin
                  em_w[n_emit] = sh; em_len[n_emit] = cur_len; em_ch[n_emit] = pws;
                  n_emit++;
               end
               cur_len = 0; sh = '0;
            end
            pws = ws;
         end
      end
      sck_prev = sck;
      sd_prev  = sd;
   end

   function automatic logic [31:0] wmask(input int w);
      return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
   endfunction

   task automatic begin_run(input int rate, input int wcode, input bit mono, input bit mute);
      cap_en = 0; in_valid = 0; rst_n = 0;
      cfg_rate = 10'(rate); cfg_width = 2'(wcode); cfg_mono = mono; cfg_mute = mute;
      repeat (3) @(posedge clk);
      n_emit = 0; cur_len = 0; sh = '0; pws = 0; ones = 0; hold_viol = 0;
      cap_every = (rate == 0);
      #1 rst_n = 1;
      @(posedge clk);
      #1 cap_en = 1;
   endtask

   task automatic push(input logic [31:0] w, output bit acc);
      @(posedge clk);
      #1 in_valid = 1; in_data = w;
      @(negedge clk) acc = in_ready;
      @(posedge clk);
      #1 in_valid = 0;
   endtask

   task automatic push_all(input int nw);
      bit acc;
      for (int k = 0; k < nw; k++) push(exp_w[k], acc);
   endtask

   task automatic run(input int cycles);
      repeat (cycles) @(posedge clk);
   endtask

   task automatic check_stream(input int nw, input bit mono, input int w, input string req);
      logic [31:0] m;
      int bad_len, bad_ch, i, bad, badt, tail, badp, reps;
      m = wmask(w);
      bad_len = 0; bad_ch = 0;
      for (int j = 0; j < n_emit; j++) begin
         if (em_len[j] != w) bad_len++;
         if (em_ch[j] !== 1'(j % 2)) bad_ch++;
      end
      check(bad_len == 0, "R3 slot length", bad_len, 0);
      check(bad_ch == 0, "R3 ws left/right order", bad_ch, 0);
      i = 0;
      while (i < n_emit && (em_w[i] & m) == 32'h0) i++;
      check(i >= 1, "R6 held word after reset is 0", i, 1);
      reps = mono ? 2 : 1;
      bad = 0;
      for (int k = 0; k < nw; k++)
         for (int r = 0; r < reps; r++) begin
            if (i >= n_emit || (em_w[i] & m) != (exp_w[k] & m)) bad++;
            i++;
         end
      check(bad == 0, req, bad, 0);
      badt = 0; tail = 0;
      while (i < n_emit) begin
         if ((em_w[i] & m) != (exp_w[nw-1] & m)) badt++;
         tail++; i++;
      end
      check(badt == 0 && tail >= 2, "R6 underflow repeats last word", badt, 0);
      if (mono) begin
         badp = 0;
         for (int j = 0; j + 1 < n_emit; j += 2)
            if (em_w[j] != em_w[j+1]) badp++;
         check(badp == 0, "R5 mono word in both slots", badp, 0);
      end
   endtask

   initial begin
      bit acc;
      int per, hi, hi_cnt, bad, nm;
      logic last;

      for (int k = 0; k < 16; k++)
         exp_w[k] = {8'(8'hC0 ^ k), 8'(8'h35 + 17*k), 8'(8'h6B + 29*k), 8'(8'h11 + 37*k)};

      // R10 reset state
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(sck == 0 && ws == 0 && sd == 0, "R10 pins low in reset", {sck, ws, sd}, 0);
      check(fifo_level == 0, "R10 level 0 in reset", fifo_level, 0);
      check(in_ready == 1, "R10 ready in reset", in_ready, 1);

      // R1 divider sweep
      for (int n = 1; n <= 7; n++) begin
         begin_run(n, 0, 0, 0);
         @(negedge clk); last = sck;
         for (int g = 0; g < 100; g++) begin
            @(negedge clk);
            if (sck && !last) break;
            last = sck;
         end
         last = sck; per = 0; hi = 0;
         for (int g = 0; g < 100; g++) begin
            @(negedge clk);
            per++;
            if (sck) hi++;
            if (sck && !last) break;
            last = sck;
         end
         check(per == n + 1, "R1 bit period", per, n + 1);
         check(hi == (n + 1) - ((n + 1) / 2), "R1 sck high time", hi, (n + 1) - ((n + 1) / 2));
      end
      begin_run(0, 0, 0, 0);
      hi_cnt = 0;
      for (int g = 0; g < 10; g++) begin @(negedge clk); if (sck) hi_cnt++; end
      check(hi_cnt == 10, "R1 divide by 1 sck high", hi_cnt, 10);

      // R4 stereo, 16-bit, upper word bits ignored (R3)
      begin_run(1, 1, 0, 0);
      push_all(6);
      run((12 * 16 + 32) * 2);
      check_stream(6, 0, 16, "R4 stereo order 16-bit");
      check(hold_viol == 0, "R2 sd steady while sck high", hold_viol, 0);

      // R5 mono, 8-bit, divider 2
      begin_run(2, 0, 1, 0);
      push_all(5);
      run((16 * 8 + 16) * 3);
      check_stream(5, 1, 8, "R5 mono order 8-bit");

      // R3 32-bit slots, width code 2
      begin_run(1, 2, 0, 0);
      push_all(4);
      run((10 * 32 + 64) * 2);
      check_stream(4, 0, 32, "R3 stereo order 32-bit");

      // R3 width code 3 also 32-bit
      begin_run(1, 3, 0, 0);
      push_all(3);
      run((9 * 32 + 64) * 2);
      check_stream(3, 0, 32, "R3 width code 3 order");

      // R1/R4 divide by 1, 8-bit stereo
      begin_run(0, 0, 0, 0);
      push_all(4);
      run(10 * 8 + 16);
      check_stream(4, 0, 8, "R4 stereo order divide by 1");

      // R7 mute
      begin_run(1, 0, 0, 1);
      push(32'h0000_005A, acc);
      push(32'h0000_00C3, acc);
      run(6 * 16 * 2);
      check(ones == 0, "R7 sd zero while muted", ones, 0);
      check(n_emit >= 10, "R7 ws runs while muted", n_emit, 10);
      check(fifo_level == 0, "R7 FIFO drained while muted", fifo_level, 0);
      nm = n_emit;
      cfg_mute = 0;
      run(6 * 16 * 2);
      bad = 0;
      for (int j = nm + 2; j < n_emit; j++) if ((em_w[j] & 32'hFF) != 32'hC3) bad++;
      check(bad == 0 && n_emit > nm + 6, "R7 unmute resumes with last word", bad, 0);

      // R8 FIFO full and drop
      begin_run(100, 0, 0, 0);
      bad = 0;
      for (int k = 0; k < 8; k++) begin
         push(exp_w[k], acc);
         if (!acc || fifo_level != 4'(k + 1)) bad++;
      end
      check(bad == 0, "R8 level counts pushes", bad, 0);
      check(in_ready == 0 && fifo_level == 8, "R8 full at 8", fifo_level, 8);
      push(32'h0000_00EE, acc);
      check(acc == 0 && fifo_level == 8, "R8 word dropped when full", fifo_level, 8);
      run((14 * 8 + 16) * 101);
      check_stream(8, 0, 8, "R8 stored words sent in order");
      check(fifo_level == 0 && in_ready == 1, "R8 level returns to 0", fifo_level, 0);
      check(hold_viol == 0, "R2 sd steady at divider 100", hold_viol, 0);

      // R9 width change mid-frame takes effect at frame boundary
      begin_run(1, 0, 0, 0);
      run(3 * 16 * 2 + 7);
      cfg_width = 2'd1;
      run(4 * 32 * 2 + 8);
      bad = 0;
      for (int j = 0; j + 1 < n_emit; j += 2) if (em_len[j] != em_len[j+1]) bad++;
      check(bad == 0, "R9 both slots same width", bad, 0);
      bad = 0;
      for (int j = 0; j < n_emit; j++) if (em_len[j] != 8 && em_len[j] != 16) bad++;
      check(bad == 0, "R9 only old or new width", bad, 0);
      check(n_emit > 6 && em_len[n_emit-1] == 16, "R9 new width applied", em_len[n_emit-1], 16);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule